// File: doc/BRIEF.md
# Single-Line NMI Controller with Trigger Select

This block watches one asynchronous non-maskable interrupt pin and raises one interrupt request toward a parent interrupt controller. The pin is resynchronized into the clock domain. One of four trigger senses is then applied: two level senses and two edge senses, chosen by software. When the selected condition is seen, a pending flag is latched. The request output is the pending flag gated by a software enable bit.

Software reaches the block over a simple register bus with an address, a write strobe, write data and combinational read data. Three word registers are decoded. A control word holds the trigger sense in its low two bits and keeps every other bit as written. A pending register is cleared by writing one. An enable register unmasks the source. A parameter picks one of two address maps, which differ only in where the enable register sits.

Top module: `nmi_line_ctrl`

## Requirements
- R1: The control word decodes at byte offset 0x00 and pending at 0x04. Enable decodes at 0x08 when MAP_ALT is 0 and at 0x34 when MAP_ALT is 1. The enable offset of the other map is not decoded.
- R2: Control bits [1:0] select the trigger sense: 0 fires while the pin is low, 1 on a high-to-low transition, 2 while the pin is high, 3 on a low-to-high transition.
- R3: A write to the control word stores all DATA_W bits, and a read returns them unchanged.
- R4: Writing a word with bit 0 set to the pending offset clears the pending flag. Writing bit 0 as 0 leaves it unchanged. Pending reads back on bit 0, and the other bits read as zero.
- R5: Enable bit 0 is stored from writes and read back on bit 0, with the other bits zero. The request output is high exactly when pending and enable are both 1.
- R6: During reset, enable, pending, the control word and the request output are all 0.
- R7: In a level sense, clearing pending while the pin still holds the active level leaves pending set on the following cycle.
- R8: In an edge sense, pending stays set until cleared. If an edge is detected in the same cycle as a clearing write, pending stays set.
- R9: Changing the trigger sense does not clear pending. A sense change made while the pin is steady does not produce an edge.
- R10: Reads of any other offset return zero. Pending sets while the source is masked.
- R11: A pin change reaches the pending flag on the third rising clock edge after it is applied, and not on an earlier edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Byte offset of the register access |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data for bus_addr |
| nmi_pin | input | 1 | Asynchronous interrupt source pin |
| irq_out | output | 1 | Interrupt request to the parent controller |

## Verification
The main check is a sweep over all four trigger senses. For each sense, the pin starts at each level and then either holds or moves to the other level, and the enable is alternated between cases. A steady pin separates the level senses from the edge senses. Transitions in each direction separate rising from falling. A held active level shows that a level-mode acknowledge is re-armed. A probe one edge before the expected latch confirms the three-edge latency. Two instances, one per address map, show that each decodes its own enable offset and ignores the other. A clearing write placed on the edge-detect cycle separates "detection wins" from "clear wins".

// File: rtl/nmi_ctrl_pkg.sv
// Package: shared sense encoding and register offsets for the NMI controller.
// Assumes byte addressing with word-aligned registers.
package nmi_ctrl_pkg;

    // Trigger sense: bit 1 is the active polarity, bit 0 selects edge mode.
    typedef enum logic [1:0] {
        SENSE_LEVEL_LOW  = 2'd0,
        SENSE_FALL_EDGE  = 2'd1,
        SENSE_LEVEL_HIGH = 2'd2,
        SENSE_RISE_EDGE  = 2'd3
    } sense_e;

    localparam logic [31:0] OFFS_CTRL  = 32'h00;
    localparam logic [31:0] OFFS_PEND  = 32'h04;
    localparam logic [31:0] OFFS_EN_A  = 32'h08;
    localparam logic [31:0] OFFS_EN_B  = 32'h34;

endpackage

// File: rtl/nmi_sync.sv
// Module: multi-stage synchronizer for the asynchronous pin, plus a
// one-cycle delayed copy of the synchronized level for edge detection.
// Assumes STAGES >= 2; all flops clear to 0 under synchronous reset.
module nmi_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_async,
    output logic level_o,
    output logic level_prev_o
);

    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    // Shift the pin through the synchronizer chain.
    generate
        for (genvar gi = 0; gi < STAGES; gi++) begin : g_stage
            if (gi == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[gi] <= 1'b0;
                    else        chain_q[gi] <= pin_async;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[gi] <= 1'b0;
                    else        chain_q[gi] <= chain_q[gi-1];
                end
            end
        end
    endgenerate

    // Keep the previous synchronized level for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= chain_q[STAGES-1];
    end

    assign level_o      = chain_q[STAGES-1];
    assign level_prev_o = prev_q;

endmodule

// File: rtl/nmi_trigger.sv
// Module: combinational trigger detector. Applies the selected sense to
// the synchronized level and its previous copy. Assumes both inputs come
// from the same clock domain, so a sense change alone cannot form an edge.
module nmi_trigger
    import nmi_ctrl_pkg::*;
(
    input  sense_e sense_i,
    input  logic   level_i,
    input  logic   level_prev_i,
    output logic   hit_o
);

    logic rise;
    logic fall;

    // Derive edges from current and previous synchronized level.
    always_comb begin
        rise = level_i & ~level_prev_i;
        fall = ~level_i & level_prev_i;
    end

    // Select the condition for the programmed sense.
    always_comb begin
        unique case (sense_i)
            SENSE_LEVEL_LOW:  hit_o = ~level_i;
            SENSE_FALL_EDGE:  hit_o = fall;
            SENSE_LEVEL_HIGH: hit_o = level_i;
            SENSE_RISE_EDGE:  hit_o = rise;
            default:          hit_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/nmi_regs.sv
// Module: register file for control, pending and enable, with address
// decode and combinational read mux. Pending is set by the trigger and
// cleared by writing one; a trigger in the same cycle takes priority.
// Assumes the three offsets are distinct and DATA_W >= 2.
module nmi_regs
    import nmi_ctrl_pkg::*;
#(
    parameter int                ADDR_W = 8,
    parameter int                DATA_W = 32,
    parameter logic [ADDR_W-1:0] A_CTRL = '0,
    parameter logic [ADDR_W-1:0] A_PEND = '0,
    parameter logic [ADDR_W-1:0] A_EN   = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              hit_i,
    output sense_e            sense_o,
    output logic              pend_o,
    output logic              en_o,
    output logic              irq_o
);

    logic [DATA_W-1:0] ctrl_q;
    logic              pend_q;
    logic              en_q;
    logic              sel_ctrl;
    logic              sel_pend;
    logic              sel_en;
    logic              clr_req;

    // Decode the register selects and the clear request.
    always_comb begin
        sel_ctrl = (bus_addr == A_CTRL);
        sel_pend = (bus_addr == A_PEND);
        sel_en   = (bus_addr == A_EN);
        clr_req  = bus_we & sel_pend & bus_wdata[0];
    end

    // Store the full control word.
    always_ff @(posedge clk) begin
        if (!rst_n)                  ctrl_q <= '0;
        else if (bus_we && sel_ctrl) ctrl_q <= bus_wdata;
    end

    // Store the enable bit.
    always_ff @(posedge clk) begin
        if (!rst_n)                en_q <= 1'b0;
        else if (bus_we && sel_en) en_q <= bus_wdata[0];
    end

    // Latch pending; a detection beats a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)       pend_q <= 1'b0;
        else if (hit_i)   pend_q <= 1'b1;
        else if (clr_req) pend_q <= 1'b0;
    end

    // Return the addressed register, or zero for unmapped offsets.
    always_comb begin
        bus_rdata = '0;
        if (sel_ctrl)      bus_rdata = ctrl_q;
        else if (sel_pend) bus_rdata[0] = pend_q;
        else if (sel_en)   bus_rdata[0] = en_q;
    end

    assign sense_o = sense_e'(ctrl_q[1:0]);
    assign pend_o  = pend_q;
    assign en_o    = en_q;
    assign irq_o   = pend_q & en_q;

endmodule

// File: rtl/nmi_line_ctrl.sv
// Module: top of the single-line NMI controller. Synchronizes the pin,
// detects the programmed trigger and exposes the register interface.
// MAP_ALT selects where the enable register is decoded.
// Assumes ADDR_W >= 6 so that every offset fits.
module nmi_line_ctrl
    import nmi_ctrl_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 32,
    parameter int SYNC_LEN = 2,
    parameter bit MAP_ALT  = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              nmi_pin,
    output logic              irq_out
);

    localparam logic [ADDR_W-1:0] ADDR_CTRL = ADDR_W'(OFFS_CTRL);
    localparam logic [ADDR_W-1:0] ADDR_PEND = ADDR_W'(OFFS_PEND);
    localparam logic [ADDR_W-1:0] ADDR_EN   = MAP_ALT ? ADDR_W'(OFFS_EN_B)
                                                      : ADDR_W'(OFFS_EN_A);

    logic   lvl;
    logic   lvl_prev;
    logic   hit;
    sense_e sense;
    logic   pend_w;
    logic   en_w;

    nmi_sync #(
        .STAGES(SYNC_LEN)
    ) u_sync (
        .clk          (clk),
        .rst_n        (rst_n),
        .pin_async    (nmi_pin),
        .level_o      (lvl),
        .level_prev_o (lvl_prev)
    );

    nmi_trigger u_trig (
        .sense_i      (sense),
        .level_i      (lvl),
        .level_prev_i (lvl_prev),
        .hit_o        (hit)
    );

    nmi_regs #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .A_CTRL (ADDR_CTRL),
        .A_PEND (ADDR_PEND),
        .A_EN   (ADDR_EN)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .hit_i     (hit),
        .sense_o   (sense),
        .pend_o    (pend_w),
        .en_o      (en_w),
        .irq_o     (irq_out)
    );

endmodule

// File: rtl/nmi_line_ctrl_chk.sv
// Checker: temporal properties on the pending flag, the enable bit and the
// request output, attached to every instance of the top by bind.
module nmi_line_ctrl_chk #(
    parameter int                ADDR_W = 8,
    parameter int                DATA_W = 32,
    parameter logic [ADDR_W-1:0] A_PEND = '0,
    parameter logic [ADDR_W-1:0] A_EN   = '0
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              irq_out,
    input logic              pend,
    input logic              en,
    input logic              hit
);

    a_r4_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_PEND && bus_wdata[0] && !hit) |=> !pend);

    a_r4_pend_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !(bus_we && bus_addr == A_PEND && bus_wdata[0])) |=> pend);

    a_r8_hit_wins: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> pend);

    a_r5_en_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_EN) |=> (en == $past(bus_wdata[0])));

    a_r5_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !irq_out);

    a_r6_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!pend && !en && !irq_out));

endmodule

bind nmi_line_ctrl nmi_line_ctrl_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .A_PEND (ADDR_PEND),
    .A_EN   (ADDR_EN)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .irq_out   (irq_out),
    .pend      (pend_w),
    .en        (en_w),
    .hit       (hit)
);

// File: tb/sim_nmi_line_ctrl.sv
`timescale 1ns/1ps
module sim_nmi_line_ctrl;

    localparam logic [7:0] A_CTRL = 8'h00;
    localparam logic [7:0] A_PEND = 8'h04;
    localparam logic [7:0] A_EN0  = 8'h08;
    localparam logic [7:0] A_EN1  = 8'h34;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = '0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic        pin = 1'b0;
    logic [31:0] rdata0, rdata1;
    logic        irq0, irq1;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    nmi_line_ctrl #(.MAP_ALT(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we),
        .bus_wdata(wdata), .bus_rdata(rdata0), .nmi_pin(pin), .irq_out(irq0));

    nmi_line_ctrl #(.MAP_ALT(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we),
        .bus_wdata(wdata), .bus_rdata(rdata1), .nmi_pin(pin), .irq_out(irq1));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Called just after a falling edge; commits on the next rising edge.
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d0, output logic [31:0] d1);
        addr = a;
        #0.5;
        d0 = rdata0;
        d1 = rdata1;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] d0, d1;
        wait_n(3);
        // R6: state during reset
        rd(A_PEND, d0, d1); chk("R6 pend", d0, 0);
        rd(A_EN0, d0, d1);  chk("R6 en", d0, 0);
        rd(A_CTRL, d0, d1); chk("R6 ctrl", d0, 0);
        chk("R6 irq", {31'b0, irq0}, 0);
        rst_n = 1'b1;
        wait_n(4);

        // R3: full control word kept (sense=3, rising)
        wr(A_CTRL, 32'hA5A5_5A03);
        rd(A_CTRL, d0, d1);
        chk("R3 ctrl u0", d0, 32'hA5A5_5A03);
        chk("R3 ctrl u1", d1, 32'hA5A5_5A03);

        // R9: level-low default with pin low set pending; sense change kept it
        rd(A_PEND, d0, d1); chk("R9 pend kept", d0, 1);

        // R1: enable offset per map
        wr(A_EN0, 1);
        rd(A_EN0, d0, d1); chk("R1 en u0 @08", d0, 1); chk("R1 en u1 @08", d1, 0);
        wr(A_EN1, 1);
        rd(A_EN1, d0, d1); chk("R1 en u0 @34", d0, 0); chk("R1 en u1 @34", d1, 1);
        chk("R5 irq u1", {31'b0, irq1}, 1);
        wr(A_EN0, 0); wr(A_EN1, 0);

        // R10: unmapped reads
        rd(8'h0C, d0, d1); chk("R10 unmapped 0C", d0, 0);
        rd(8'hFC, d0, d1); chk("R10 unmapped FC", d1, 0);

        // R10: pending sets while masked (rising)
        wr(A_PEND, 1);
        rd(A_PEND, d0, d1); chk("R4 cleared", d0, 0);
        pin = 1'b1; wait_n(3);
        rd(A_PEND, d0, d1); chk("R10 masked pend", d0, 1);
        chk("R10 masked irq", {31'b0, irq0}, 0);

        // R4: write 0 no effect, write 1 clears
        wr(A_PEND, 0);
        rd(A_PEND, d0, d1); chk("R4 zero write", d0, 1);
        wr(A_PEND, 32'hFFFF_FFFF);
        rd(A_PEND, d0, d1); chk("R4 one write", d0, 0);

        // R8: edge in same cycle as clear
        pin = 1'b0; wait_n(4);
        wr(A_PEND, 1);
        pin = 1'b1; wait_n(2);
        wr(A_PEND, 1);
        rd(A_PEND, d0, d1); chk("R8 edge beats clear", d0, 1);
        wait_n(3);
        rd(A_PEND, d0, d1); chk("R8 sticky", d0, 1);

        // R2/R5/R7/R9/R11 sweep over sense, start level, end level
        for (int s = 0; s < 4; s++) begin
            for (int a = 0; a < 2; a++) begin
                for (int b = 0; b < 2; b++) begin
                    logic pol, edg, e, exp1, exp2;
                    pol = s[1]; edg = s[0];
                    e = (s + a + b) % 2 == 1;
                    exp1 = !edg && (a == pol);
                    exp2 = exp1 | (edg ? (a != b && b == pol) : (b == pol));
                    pin = a[0];
                    wr(A_CTRL, 32'h0000_0F03);
                    wait_n(4);
                    wr(A_PEND, 1);
                    wr(A_CTRL, 32'h0000_0F00 | s);
                    wait_n(3);
                    rd(A_PEND, d0, d1);
                    chk($sformatf("R9 s%0d a%0d after sense change", s, a), d0, exp1);
                    wr(A_EN0, {31'b0, e});
                    pin = b[0];
                    wait_n(2);
                    rd(A_PEND, d0, d1);
                    chk($sformatf("R11 s%0d a%0d b%0d early", s, a, b), d0, exp1);
                    wait_n(1);
                    rd(A_PEND, d0, d1);
                    chk($sformatf("R2 s%0d a%0d b%0d pend", s, a, b), d0, exp2);
                    chk($sformatf("R5 s%0d a%0d b%0d irq", s, a, b), {31'b0, irq0}, {31'b0, exp2 & e});
                end
            end
        end

        // R7: level ack while level held
        wr(A_CTRL, 2); pin = 1'b1; wait_n(4);
        wr(A_PEND, 1);
        rd(A_PEND, d0, d1); chk("R7 rearm", d0, 1);
        pin = 1'b0; wait_n(4);
        wr(A_PEND, 1);
        rd(A_PEND, d0, d1); chk("R7 released", d0, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule